// File: doc/BRIEF.md
# Three-Deep Evaluation Stack Execution Core

This block executes the data-path side of a zero-address stack machine. It holds a three-register evaluation stack (top A, then B, then C) and a workspace pointer. Local variables are kept in a fast local RAM at word offsets from the workspace pointer, not in registers. A process switch therefore replaces only the pointer. An upstream decoder presents one function code and a full-width operand per transfer on a valid/ready channel. The core drives read and write strobes to a single-cycle local RAM and shows the stack and workspace pointer on its outputs.

The instruction channel follows the usual valid/ready rules. A transfer happens on a rising edge where `ins_valid` and `ins_ready` are both high. Once the source asserts `ins_valid`, it must hold the code and operand steady until the transfer happens. `ins_ready` drops for exactly one cycle after a local load is accepted, while the core waits for the RAM word. Every other function keeps `ins_ready` high, so those functions can be issued back to back. Storing a constant into a local therefore takes two cycles.

Top module: `stk_core`

## Requirements
- R1: After reset, A, B and C read 0, the workspace pointer equals the `WP_INIT` parameter (default 0), `ins_ready` is high, and neither RAM strobe is active.
- R2: Load constant (code 0) completes on its transfer edge. After that edge A holds the operand, B holds the old A and C holds the old B. `ins_ready` stays high.
- R3: Load local (code 1) raises `mem_rd_en` during the transfer cycle, with `mem_addr` = workspace pointer + 4 × operand. `ins_ready` is low in the next cycle. At the end of that cycle the returned RAM word is pushed as in R2.
- R4: Store local (code 2) raises `mem_wr_en` during the transfer cycle, with the R3 address and `mem_wr_data` equal to A. On the edge, B moves into A, C moves into B, and C keeps its value.
- R5: Add (code 3) leaves B + A (modulo 2^DATA_W) in A, moves C into B and keeps C.
- R6: Subtract (code 4) leaves B − A (modulo 2^DATA_W) in A, moves C into B and keeps C.
- R7: Workspace switch (code 5) loads the workspace pointer from the low `ADDR_W` bits of A, with bits 1:0 forced to zero, then pops as in R4. Later local accesses use the new pointer, and locals written under the old pointer keep their values.
- R8: A cycle without a transfer changes no stack register and no pointer, and raises no strobe. An offered instruction is not consumed while `ins_ready` is low.
- R9: Codes 6 and 7 are accepted in one cycle and change nothing.
- R10: Local addresses wrap modulo 2^ADDR_W bytes. At most one RAM strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Core can take an instruction |
| ins_fn | input | 3 | Function code (see R2–R9) |
| ins_operand | input | DATA_W | Constant or local word offset |
| mem_rd_en | output | 1 | Local RAM read strobe |
| mem_wr_en | output | 1 | Local RAM write strobe |
| mem_addr | output | ADDR_W | Byte address of the local word |
| mem_wr_data | output | DATA_W | Word to write |
| mem_rd_data | input | DATA_W | Word returned one cycle after a read |
| stk_a | output | DATA_W | Stack top |
| stk_b | output | DATA_W | Second stack entry |
| stk_c | output | DATA_W | Third stack entry |
| wptr | output | ADDR_W | Current workspace pointer |

## Verification
A stack shift in the wrong direction shows on `stk_a`/`stk_b`/`stk_c` on the edge right after the transfer. A pointer fault first shows as a wrong `mem_addr` on the next local access, and later as wrong data when a local is read back. A load-wait flag that is stuck or missing shows either as `ins_ready` failing to drop in the cycle after a load, or as a following instruction being taken in place of the RAM word. Random sequences that mix stores, switches and reloads expose a lost or misdirected write at the first read-back of that local.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    FN_LDC = 3'd0,
    FN_LDL = 3'd1,
    FN_STL = 3'd2,
    FN_ADD = 3'd3,
    FN_SUB = 3'd4,
    FN_SWP = 3'd5
  } fn_e;
endpackage

// File: rtl/stk_regs.sv
module stk_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_push,
  input  logic              do_pop,
  input  logic              do_fold,
  input  logic [DATA_W-1:0] push_val,
  input  logic [DATA_W-1:0] fold_val,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] b_q,
  output logic [DATA_W-1:0] c_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (do_push) begin
      c_q <= b_q;
      b_q <= a_q;
      a_q <= push_val;
    end else if (do_pop) begin
      a_q <= b_q;
      b_q <= c_q;
    end else if (do_fold) begin
      a_q <= fold_val;
      b_q <= c_q;
    end
  end
endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int DATA_W = 32
) (
  input  logic              sub,
  input  logic [DATA_W-1:0] top,
  input  logic [DATA_W-1:0] second,
  output logic [DATA_W-1:0] result
);
  always_comb result = sub ? (second - top) : (second + top);
endmodule

// File: rtl/stk_addr.sv
module stk_addr #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-3:0] word_off,
  output logic [ADDR_W-1:0] byte_addr
);
  always_comb byte_addr = base + {word_off, 2'b00};
endmodule

// File: rtl/stk_core.sv
module stk_core #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 10,
  parameter int WP_INIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [2:0]        ins_fn,
  input  logic [DATA_W-1:0] ins_operand,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic [DATA_W-1:0] stk_a,
  output logic [DATA_W-1:0] stk_b,
  output logic [DATA_W-1:0] stk_c,
  output logic [ADDR_W-1:0] wptr
);
  import stk_pkg::*;

  localparam logic [ADDR_W-1:0] WP_RST = ADDR_W'(WP_INIT) & ~ADDR_W'(3);

  logic              wait_q;
  logic              take;
  logic              is_ldc, is_ldl, is_stl, is_add, is_sub, is_swp;
  logic              do_push, do_pop, do_fold;
  logic [DATA_W-1:0] push_val, alu_res;
  logic [ADDR_W-1:0] wp_q;

  assign ins_ready = !wait_q;
  assign take      = ins_valid && ins_ready;

  always_comb begin
    is_ldc = take && (ins_fn == FN_LDC);
    is_ldl = take && (ins_fn == FN_LDL);
    is_stl = take && (ins_fn == FN_STL);
    is_add = take && (ins_fn == FN_ADD);
    is_sub = take && (ins_fn == FN_SUB);
    is_swp = take && (ins_fn == FN_SWP);
  end

  assign do_push  = is_ldc || wait_q;
  assign do_pop   = is_stl || is_swp;
  assign do_fold  = is_add || is_sub;
  assign push_val = wait_q ? mem_rd_data : ins_operand;

  always_ff @(posedge clk) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= is_ldl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      wp_q <= WP_RST;
    else if (is_swp) wp_q <= {stk_a[ADDR_W-1:2], 2'b00};
  end

  stk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .do_push  (do_push),
    .do_pop   (do_pop),
    .do_fold  (do_fold),
    .push_val (push_val),
    .fold_val (alu_res),
    .a_q      (stk_a),
    .b_q      (stk_b),
    .c_q      (stk_c)
  );

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .sub    (is_sub),
    .top    (stk_a),
    .second (stk_b),
    .result (alu_res)
  );

  stk_addr #(.ADDR_W(ADDR_W)) u_addr (
    .base      (wp_q),
    .word_off  (ins_operand[ADDR_W-3:0]),
    .byte_addr (mem_addr)
  );

  assign mem_rd_en   = is_ldl;
  assign mem_wr_en   = is_stl;
  assign mem_wr_data = stk_a;
  assign wptr        = wp_q;
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [2:0]        ins_fn,
  input logic [DATA_W-1:0] ins_operand,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic [DATA_W-1:0] stk_a,
  input logic [DATA_W-1:0] stk_b,
  input logic [DATA_W-1:0] stk_c,
  input logic [ADDR_W-1:0] wptr
);
  a_r3_wait_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && ins_fn == 3'd1) |=> !ins_ready);

  a_r2_ldc_push: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && ins_fn == 3'd0) |=>
      (stk_a == $past(ins_operand) && stk_b == $past(stk_a) && stk_c == $past(stk_b)));

  a_r4_store_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_wr_data == stk_a && ins_valid && ins_ready));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |-> (!mem_rd_en && !mem_wr_en));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ready && !ins_valid) |=>
      ($stable(stk_a) && $stable(stk_b) && $stable(stk_c) && $stable(wptr)));

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_en, mem_wr_en}));

  a_r7_wp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wptr[1:0] == 2'b00);
endmodule

bind stk_core stk_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ins_valid   (ins_valid),
  .ins_ready   (ins_ready),
  .ins_fn      (ins_fn),
  .ins_operand (ins_operand),
  .mem_rd_en   (mem_rd_en),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_data (mem_wr_data),
  .stk_a       (stk_a),
  .stk_b       (stk_b),
  .stk_c       (stk_c),
  .wptr        (wptr)
);

// File: tb/stk_core_test.sv
module stk_core_test;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam int NW = 1 << (AW - 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0;
  logic          ins_ready;
  logic [2:0]    ins_fn = '0;
  logic [DW-1:0] ins_operand = '0;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wr_data;
  logic [DW-1:0] mem_rd_data;
  logic [DW-1:0] stk_a, stk_b, stk_c;
  logic [AW-1:0] wptr;

  logic [DW-1:0] ram [NW];
  logic [DW-1:0] emem [NW];
  logic [DW-1:0] ma, mb, mc;
  logic [AW-1:0] mwp;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stk_core #(.DATA_W(DW), .ADDR_W(AW), .WP_INIT(0)) uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_fn(ins_fn), .ins_operand(ins_operand), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_data(mem_rd_data), .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c),
    .wptr(wptr)
  );

  always_ff @(posedge clk) begin
    if (mem_wr_en) ram[mem_addr[AW-1:2]] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= ram[mem_addr[AW-1:2]];
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] f_addr(input logic [AW-1:0] wp, input logic [DW-1:0] op);
    return wp + {op[AW-3:0], 2'b00};
  endfunction

  task automatic m_apply(input logic [2:0] fn, input logic [DW-1:0] op);
    logic [AW-1:0] ad;
    ad = f_addr(mwp, op);
    case (fn)
      3'd0: begin mc = mb; mb = ma; ma = op; end
      3'd1: begin mc = mb; mb = ma; ma = emem[ad[AW-1:2]]; end
      3'd2: begin emem[ad[AW-1:2]] = ma; ma = mb; mb = mc; end
      3'd3: begin ma = mb + ma; mb = mc; end
      3'd4: begin ma = mb - ma; mb = mc; end
      3'd5: begin mwp = {ma[AW-1:2], 2'b00}; ma = mb; mb = mc; end
      default: ;
    endcase
  endtask

  task automatic cmp_state(input string req);
    chk(stk_a == ma, {req, " A"}, stk_a, ma);
    chk(stk_b == mb, {req, " B"}, stk_b, mb);
    chk(stk_c == mc, {req, " C"}, stk_c, mc);
    chk(wptr == mwp, {req, " wptr"}, DW'(wptr), DW'(mwp));
  endtask

  // Called at a negedge; returns at a negedge with the instruction complete.
  task automatic do_ins(input logic [2:0] fn, input logic [DW-1:0] op, input string req);
    logic [AW-1:0] ad;
    while (!ins_ready) @(negedge clk);
    ad = f_addr(mwp, op);
    ins_valid = 1'b1; ins_fn = fn; ins_operand = op;
    #1;
    if (fn == 3'd1) begin
      chk(mem_rd_en && !mem_wr_en, {req, " R3 read strobe"}, DW'(mem_rd_en), 1);
      chk(mem_addr == ad, {req, " R3 addr"}, DW'(mem_addr), DW'(ad));
    end else if (fn == 3'd2) begin
      chk(mem_wr_en && !mem_rd_en, {req, " R4 write strobe"}, DW'(mem_wr_en), 1);
      chk(mem_addr == ad, {req, " R10 addr"}, DW'(mem_addr), DW'(ad));
      chk(mem_wr_data == ma, {req, " R4 wdata"}, mem_wr_data, ma);
    end else begin
      chk(!mem_rd_en && !mem_wr_en, {req, " R10 no strobe"}, DW'({mem_rd_en, mem_wr_en}), 0);
    end
    @(negedge clk);
    ins_valid = 1'b0;
    m_apply(fn, op);
    if (fn == 3'd1) begin
      chk(!ins_ready, {req, " R3 ready low"}, DW'(ins_ready), 0);
      @(negedge clk);
    end
    cmp_state(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int t0;
    logic [DW-1:0] seed;
    for (int i = 0; i < NW; i++) begin ram[i] = '0; emem[i] = '0; end
    ma = '0; mb = '0; mc = '0; mwp = '0;
    seed = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cmp_state("R1 reset");
    chk(ins_ready, "R1 ready", DW'(ins_ready), 1);
    chk(!mem_rd_en && !mem_wr_en, "R1 strobes", DW'({mem_rd_en, mem_wr_en}), 0);

    // R2 / R4: constant store to a local in two cycles
    t0 = cyc;
    do_ins(3'd0, 32'd1, "R2 ldc 1");
    do_ins(3'd2, 32'd5, "R4 stl 5");
    chk(cyc - t0 == 2, "R2 R4 two-cycle assign", DW'(cyc - t0), 2);
    do_ins(3'd1, 32'd5, "R3 ldl 5");

    // R5 R6 arithmetic with wrap
    do_ins(3'd0, 32'hFFFF_FFFF, "R2 ldc max");
    do_ins(3'd0, 32'd3, "R2 ldc 3");
    do_ins(3'd3, 32'd0, "R5 add wrap");
    do_ins(3'd0, 32'd9, "R2 ldc 9");
    do_ins(3'd4, 32'd0, "R6 sub borrow");

    // R9 unused codes
    do_ins(3'd6, 32'd77, "R9 code6");
    do_ins(3'd7, 32'd78, "R9 code7");

    // R7 switch workspace, old locals preserved
    do_ins(3'd0, 32'h0000_0123, "R7 ldc new wp");
    do_ins(3'd5, 32'd0, "R7 switch");
    do_ins(3'd0, 32'hABCD, "R7 ldc");
    do_ins(3'd2, 32'd2, "R7 stl new ws");
    do_ins(3'd0, 32'd0, "R7 ldc 0");
    do_ins(3'd5, 32'd0, "R7 switch back");
    do_ins(3'd1, 32'd5, "R7 old local kept");

    // R10 address wrap
    do_ins(3'd0, 32'h3F0, "R10 ldc");
    do_ins(3'd5, 32'd0, "R10 switch high");
    do_ins(3'd0, 32'h55, "R10 ldc");
    do_ins(3'd2, 32'd10, "R10 stl wraps");
    do_ins(3'd1, 32'd10, "R10 ldl wraps");

    // R8 idle cycles with junk on the bus
    for (int i = 0; i < 3; i++) begin
      ins_fn = 3'd3; ins_operand = 32'hDEAD;
      #1;
      chk(!mem_rd_en && !mem_wr_en, "R8 idle strobes", DW'({mem_rd_en, mem_wr_en}), 0);
      @(negedge clk);
      cmp_state("R8 idle");
    end

    // R8 instruction held while load pending
    while (!ins_ready) @(negedge clk);
    ins_valid = 1'b1; ins_fn = 3'd1; ins_operand = 32'd5;
    @(negedge clk);
    m_apply(3'd1, 32'd5);
    ins_fn = 3'd0; ins_operand = 32'd77;
    chk(!ins_ready, "R8 ready low during wait", DW'(ins_ready), 0);
    @(negedge clk);
    cmp_state("R8 load before held ldc");
    @(negedge clk);
    ins_valid = 1'b0;
    m_apply(3'd0, 32'd77);
    cmp_state("R8 held ldc taken once");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] fn;
      logic [DW-1:0] op;
      fn = 3'($urandom_range(0, 7));
      op = (fn == 3'd0 || fn > 3'd4) ? DW'($urandom) : DW'($urandom_range(0, 15));
      do_ins(fn, op, "R2 R3 R4 R5 R6 R7 random");
      if ($urandom_range(0, 5) == 0) @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule